// File: doc/BRIEF.md
# Register-Array LIFO Stack with Occupancy Flags

This block is a last-in-first-out store of 64 words kept in a register array. A 6-bit stack pointer always addresses the word on top. A push request moves the pointer up by one and writes the input word into the slot it now addresses. A pop request copies the word under the pointer into the data register and then moves the pointer down by one. The data register also takes the pushed word on a push, so it always shows the word that last moved into or out of the stack.

Occupancy is held in a three-state machine. The states are EMPTY, PARTIAL and FULL, and the full and empty flags are decoded from the state. The machine has these transitions. From EMPTY, a push goes to PARTIAL, or to FULL if the incremented pointer wraps to zero, which happens only with a depth of one. From PARTIAL, a push goes to FULL when the incremented pointer wraps to zero and otherwise stays in PARTIAL. From PARTIAL, a pop goes to EMPTY when the decremented pointer reaches zero and otherwise stays in PARTIAL. From FULL, a pop goes to EMPTY or to PARTIAL by the same test. A push in FULL and a pop in EMPTY are refused: the state stays where it is and a one-cycle error pulse is raised. No count is compared against the depth. The pointer wrapping to zero is the only test.

Requests are sampled on the rising clock edge. The data register, the flags and the error pulse all change on that same edge, so they are valid in the cycle after the request.

Top module: `lifo_reg_stack`

## Requirements
- R1: After reset, empty is 1, full is 0, err is 0 and dout is 0.
- R2: A push (push_req=1, pop_req=0) made while full is 0 is accepted. On the next clock, dout equals the pushed din, empty is 0 and err is 0.
- R3: A pop (pop_req=1, push_req=0) made while empty is 0 is accepted. On the next clock, dout holds the most recently pushed word that has not yet been popped.
- R4: Starting from empty, full becomes 1 exactly on the clock that accepts the 64th push, and not before.
- R5: A push made while full is 1 changes neither the stored words, the flags nor dout, and err is 1 for exactly the following cycle.
- R6: A pop made while empty is 1 leaves the flags and dout unchanged, and err is 1 for exactly the following cycle.
- R7: When push_req and pop_req are both 1, nothing happens: the pointer, the contents, the flags and dout are unchanged, and err stays 0.
- R8: Every accepted pop clears full. The pop that removes the last stored word sets empty.
- R9: full and empty are never 1 at the same time.
- R10: err is 1 only in the cycle after a refused request. Once requests stop, it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push din onto the stack |
| pop_req | input | 1 | Request to pop the top word |
| din | input | 16 | Word to push |
| dout | output | 16 | Data register: last word pushed or popped |
| full | output | 1 | All 64 words are in use |
| empty | output | 1 | No words are stored |
| err | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
The assertions check the local rules on every cycle:
- the two flags are never 1 together;
- a refused push or pop leaves the flags in place and raises err;
- colliding requests change nothing;
- an accepted push shows its word in dout and clears empty;
- an accepted pop clears full.

Some behaviour needs a whole sequence and only the bench scenarios can show it. This covers the LIFO ordering of all 64 words, full appearing at exactly the 64th push, and the stored contents surviving a refused push. The bench fills and drains the whole stack with computed words, then runs an interleaved sequence that includes colliding requests.

// File: rtl/lifo_stk_pkg.sv
package lifo_stk_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } op_e;
endpackage

// File: rtl/lifo_stk_mem.sv
module lifo_stk_mem #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] raddr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dr
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] slots [DEPTH];

    // Storage carries no reset; only written slots are ever read.
    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    // Data register: takes the pushed word or the popped word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr <= '0;
        end else if (we) begin
            dr <= wdata;
        end else if (re) begin
            dr <= slots[raddr];
        end
    end
endmodule

// File: rtl/lifo_stk_ptr.sv
module lifo_stk_ptr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_inc,
    output logic          inc_wraps,
    output logic          dec_wraps
);
    logic [AW-1:0] sp_dec;

    always_comb begin
        sp_inc    = sp + 1'b1;
        sp_dec    = sp - 1'b1;
        inc_wraps = (sp_inc == '0);
        dec_wraps = (sp_dec == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (inc) begin
            sp <= sp_inc;
        end else if (dec) begin
            sp <= sp_dec;
        end
    end
endmodule

// File: rtl/lifo_stk_ctrl.sv
module lifo_stk_ctrl
    import lifo_stk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic pop_req,
    input  logic inc_wraps,
    input  logic dec_wraps,
    output logic do_push,
    output logic do_pop,
    output logic full,
    output logic empty,
    output logic err
);
    occ_e state, state_nxt;
    op_e  op;
    logic err_nxt;

    always_comb begin
        unique case ({push_req, pop_req})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_CLASH;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        state_nxt = state;
        err_nxt   = 1'b0;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (state == ST_FULL) begin
                    err_nxt = 1'b1;
                end else begin
                    do_push   = 1'b1;
                    state_nxt = inc_wraps ? ST_FULL : ST_PARTIAL;
                end
            end
            OP_POP: begin
                if (state == ST_EMPTY) begin
                    err_nxt = 1'b1;
                end else begin
                    do_pop    = 1'b1;
                    state_nxt = dec_wraps ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: begin
                state_nxt = state;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            err   <= 1'b0;
        end else begin
            state <= state_nxt;
            err   <= err_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_EMPTY:   begin empty = 1'b1; full = 1'b0; end
            ST_FULL:    begin empty = 1'b0; full = 1'b1; end
            default:    begin empty = 1'b0; full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack #(
    parameter int W  = 16,
    parameter int AW = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic         pop_req,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         err
);
    logic          do_push, do_pop;
    logic          inc_wraps, dec_wraps;
    logic [AW-1:0] sp, sp_inc;

    lifo_stk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .inc_wraps (inc_wraps),
        .dec_wraps (dec_wraps),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .full      (full),
        .empty     (empty),
        .err       (err)
    );

    lifo_stk_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (do_push),
        .dec       (do_pop),
        .sp        (sp),
        .sp_inc    (sp_inc),
        .inc_wraps (inc_wraps),
        .dec_wraps (dec_wraps)
    );

    lifo_stk_mem #(.W(W), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_push),
        .re    (do_pop),
        .waddr (sp_inc),
        .raddr (sp),
        .wdata (din),
        .dr    (dout)
    );
endmodule

// File: rtl/lifo_reg_stack_chk.sv
module lifo_reg_stack_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_req,
    input logic         pop_req,
    input logic [W-1:0] din,
    input logic [W-1:0] dout,
    input logic         full,
    input logic         empty,
    input logic         err
);
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_push_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !full) |=> (!empty && !err && dout == $past(din)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && full) |=> (full && err && $stable(dout)));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && empty) |=> (empty && err && $stable(dout)));

    p_clash_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> (!err && $stable(full) && $stable(empty) && $stable(dout)));

    p_pop_clears_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !empty) |=> (!full && !err));

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(push_req != pop_req));
endmodule

bind lifo_reg_stack lifo_reg_stack_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .din      (din),
    .dout     (dout),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/lifo_reg_stack_tb.sv
module lifo_reg_stack_tb;
    localparam int W     = 16;
    localparam int DEPTH = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_req = 1'b0;
    logic         pop_req = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         full, empty, err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lifo_reg_stack u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .din      (din),
        .dout     (dout),
        .full     (full),
        .empty    (empty),
        .err      (err)
    );

    function automatic logic [W-1:0] word_of(input int i);
        return W'((i * 16'd40503 + 16'h1234) ^ (i << 9));
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge with results settled.
    task automatic step(input logic p, input logic q, input logic [W-1:0] d);
        push_req = p;
        pop_req  = q;
        din      = d;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", W'(empty), 1);
        check("R1 full", W'(full), 0);
        check("R1 err", W'(err), 0);
        check("R1 dout", dout, 0);

        // R2 R4: fill the whole stack
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, word_of(i));
            check("R2 dout", dout, word_of(i));
            check("R2 empty", W'(empty), 0);
            check("R2 err", W'(err), 0);
            check("R4 full", W'(full), W'(i == DEPTH - 1));
        end

        // R5 overflow refused
        step(1'b1, 1'b0, 16'hDEAD);
        check("R5 err", W'(err), 1);
        check("R5 full", W'(full), 1);
        check("R5 dout", dout, word_of(DEPTH - 1));
        step(1'b0, 1'b0, '0);
        check("R10 err drop", W'(err), 0);

        // R7 clash while full
        step(1'b1, 1'b1, 16'hBEEF);
        check("R7 err", W'(err), 0);
        check("R7 full", W'(full), 1);
        check("R7 dout", dout, word_of(DEPTH - 1));

        // R3 R8: drain in reverse order
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b0, 1'b1, '0);
            check("R3 dout", dout, word_of(DEPTH - 1 - k));
            check("R8 full", W'(full), 0);
            check("R8 empty", W'(empty), W'(k == DEPTH - 1));
            check("R3 err", W'(err), 0);
        end

        // R6 underflow refused
        step(1'b0, 1'b1, '0);
        check("R6 err", W'(err), 1);
        check("R6 empty", W'(empty), 1);
        check("R6 dout", dout, word_of(0));
        step(1'b0, 1'b0, '0);
        check("R10 err drop", W'(err), 0);

        // R7 clash while empty
        step(1'b1, 1'b1, 16'h7777);
        check("R7 empty", W'(empty), 1);
        check("R7 err", W'(err), 0);
        check("R7 dout", dout, word_of(0));

        // Interleaved sequence with a clash in the middle
        step(1'b1, 1'b0, 16'h1111);
        step(1'b1, 1'b0, 16'h2222);
        step(1'b1, 1'b1, 16'h3333);
        check("R7 dout mid", dout, 16'h2222);
        step(1'b0, 1'b1, '0);
        check("R3 pop b", dout, 16'h2222);
        step(1'b1, 1'b0, 16'h4444);
        check("R2 push c", dout, 16'h4444);
        step(1'b0, 1'b1, '0);
        check("R3 pop c", dout, 16'h4444);
        check("R8 not empty", W'(empty), 0);
        step(1'b0, 1'b1, '0);
        check("R3 pop a", dout, 16'h1111);
        check("R8 empty last", W'(empty), 1);
        check("R9 flags", W'(full & empty), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule